// File: doc/BRIEF.md
# Triple-Line Redundant Frame Receiver

This block is the receive end of a serial master-slave field bus in which every transmitter sends the same frame at the same moment on three independent cables. The three lines reach the block already sampled and bit-aligned. A single `bit_en` strobe marks each bit time, which is one strobe per bit at 10 Mbit/s. On every strobe the block takes a two-out-of-three vote across the lines. It then finds frames in the voted stream and checks their integrity with a 16-bit CRC. Because of the vote, a cable that is cut, shorted or inverted does not cost a single frame.

A frame is sent MSB first as a sync byte 0x7E, a destination address byte, a length byte N, N payload bytes and a 16-bit CRC. The block delivers the payload of frames sent to its configured node address or to broadcast 0xFF. Each byte appears as it completes. The block ends each such frame with a one-cycle good or error pulse. It keeps a sticky fault mask with one bit per line, which shows which cables disagreed with the vote during the current frame. Maintenance logic reads this mask to locate failing cabling.

Top module: `tlr_frame_rx`

## Requirements
- R1: Each received bit is the majority of the three line values at a `bit_en` strobe. With any one line stuck at 0, stuck at 1 or inverted for a whole frame, the frame is delivered and judged exactly as on clean lines.
- R2: A frame starts only when the last eight voted bits equal 0x7E while the receiver is hunting. The pattern on a single line, with the other two lines low, starts nothing and leaves every output unchanged.
- R3: After the sync byte come an address byte, a length byte and the payload bytes, then the CRC high byte and the CRC low byte. All are MSB first.
- R4: The CRC uses polynomial 0x1021 with start value 0xFFFF and covers the address, length and payload bytes. For a frame sent to this node or to 0xFF whose CRC matches, `frame_ok` pulses for one clock, one cycle after the strobe of the last CRC bit.
- R5: For a frame sent to this node or to 0xFF whose CRC does not match, `frame_err` pulses for one clock in that same cycle.
- R6: A frame whose address is neither `node_addr` nor 0xFF produces no byte pulse, no `frame_ok` and no `frame_err`, whatever its CRC.
- R7: In an accepted frame, each payload byte appears on `rx_byte` with a one-cycle `rx_byte_valid` pulse one cycle after the strobe of its last bit. This happens before the CRC verdict. A 0x7E byte inside the payload does not restart framing.
- R8: A length byte of 0 or of more than 16 abandons the frame right after that byte. For an accepted address, `frame_err` pulses once and no payload byte is delivered. The receiver then hunts for the next sync byte.
- R9: Bit k of `line_fault` is set when line k differed from the vote on any bit after the sync byte of the current frame. It is cleared when the next sync byte is detected, and otherwise it holds between frames.
- R10: After reset, every output is 0, and `frame_ok` and `frame_err` are never high together.
- R11: Line values are taken only at `bit_en` strobes. Line activity between strobes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One-cycle strobe per received bit |
| line_in | input | NLINES (3) | Sampled, aligned values of the redundant lines |
| node_addr | input | 8 | Address of this node |
| rx_byte_valid | output | 1 | Pulse marking a delivered payload byte |
| rx_byte | output | 8 | Payload byte, valid with `rx_byte_valid` |
| frame_ok | output | 1 | Pulse: accepted frame, CRC correct |
| frame_err | output | 1 | Pulse: accepted frame, CRC wrong or length illegal |
| line_fault | output | NLINES (3) | Sticky per-line disagreement mask for the current frame |

## Verification
The hardest case to reach from the ports is a vote that is itself wrong. This happens when two lines carry the same wrong bit. The CRC must then fail, and the fault mask must point at the one healthy line instead of the two faulty ones. The stimulus drives each line separately and XORs a chosen mask of lines into one selected bit of the frame, which creates exactly that coincidence. The same per-line drive sweeps every line through stuck-low, stuck-high and inverted faults, and it toggles the lines between strobes.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_ADDR,
    ST_LEN,
    ST_DATA,
    ST_CRC
  } rx_state_e;

  localparam logic [7:0]  SYNC_BYTE  = 8'h7E;
  localparam logic [7:0]  BCAST_ADDR = 8'hFF;
  localparam int          CRC_W      = 16;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
endpackage

// File: rtl/tlr_vote.sv
module tlr_vote #(
  parameter int NLINES = 3
) (
  input  logic [NLINES-1:0] line_in,
  output logic              voted,
  output logic [NLINES-1:0] disagree
);
  localparam int CW = $clog2(NLINES + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NLINES; i++) begin
      ones = ones + CW'(line_in[i]);
    end
  end

  assign voted = (ones > CW'(NLINES / 2));

  for (genvar g = 0; g < NLINES; g++) begin : g_dis
    assign disagree[g] = line_in[g] ^ voted;
  end
endmodule

// File: rtl/tlr_crc_ser.sv
module tlr_crc_ser
  import tlr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_nxt_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  assign crc_nxt_o = {crc_q[CRC_W-2:0], 1'b0}
                   ^ ({CRC_W{crc_q[CRC_W-1] ^ bit_i}} & CRC_POLY);

  always_comb begin
    crc_d = crc_q;
    if (init_i)      crc_d = CRC_SEED;
    else if (step_i) crc_d = crc_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assert_seed_after_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/tlr_deframer.sv
module tlr_deframer
  import tlr_pkg::*;
#(
  parameter int NLINES  = 3,
  parameter int MAX_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              vbit_i,
  input  logic [NLINES-1:0] mm_i,
  input  logic [7:0]        my_addr_i,
  input  logic [CRC_W-1:0]  crc_nxt_i,
  output logic              crc_init_o,
  output logic              crc_step_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  output logic              frame_ok_o,
  output logic              frame_err_o,
  output logic [NLINES-1:0] line_fault_o
);
  localparam int         LEN_W     = $clog2(MAX_LEN + 1);
  localparam logic [7:0] MAX_LEN_B = 8'(MAX_LEN);

  rx_state_e         state_q, state_d;
  logic [7:0]        sr_q, sr_d, sr_n;
  logic [2:0]        bitc_q, bitc_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic              hit_q, hit_d;
  logic [NLINES-1:0] flt_q, flt_d;
  logic              bv_q, bv_d, ok_q, ok_d, err_q, err_d;
  logic [7:0]        bd_q, bd_d;

  assign sr_n = {sr_q[6:0], vbit_i};

  always_comb begin
    state_d    = state_q;
    sr_d       = sr_q;
    bitc_d     = bitc_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    hit_d      = hit_q;
    flt_d      = flt_q;
    bd_d       = bd_q;
    bv_d       = 1'b0;
    ok_d       = 1'b0;
    err_d      = 1'b0;
    crc_init_o = 1'b0;
    crc_step_o = 1'b0;
    if (bit_en_i) begin
      if (state_q == ST_HUNT) begin
        if (sr_n == SYNC_BYTE) begin
          state_d    = ST_ADDR;
          sr_d       = '0;
          bitc_d     = '0;
          flt_d      = '0;
          crc_init_o = 1'b1;
        end else begin
          sr_d = sr_n;
        end
      end else begin
        sr_d       = sr_n;
        crc_step_o = 1'b1;
        flt_d      = flt_q | mm_i;
        bitc_d     = bitc_q + 3'd1;
        if (bitc_q == 3'd7) begin
          unique case (state_q)
            ST_ADDR: begin
              hit_d   = (sr_n == my_addr_i) || (sr_n == BCAST_ADDR);
              state_d = ST_LEN;
            end
            ST_LEN: begin
              if (sr_n == 8'd0 || sr_n > MAX_LEN_B) begin
                err_d   = hit_q;
                state_d = ST_HUNT;
                sr_d    = '0;
              end else begin
                len_d   = LEN_W'(sr_n);
                cnt_d   = '0;
                state_d = ST_DATA;
              end
            end
            ST_DATA: begin
              bv_d = hit_q;
              if (hit_q) bd_d = sr_n;
              if (cnt_q + LEN_W'(1) == len_q) begin
                cnt_d   = '0;
                state_d = ST_CRC;
              end else begin
                cnt_d = cnt_q + LEN_W'(1);
              end
            end
            ST_CRC: begin
              if (cnt_q != '0) begin
                ok_d    = hit_q && (crc_nxt_i == '0);
                err_d   = hit_q && (crc_nxt_i != '0);
                state_d = ST_HUNT;
                sr_d    = '0;
              end else begin
                cnt_d = LEN_W'(1);
              end
            end
            default: state_d = ST_HUNT;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      sr_q    <= '0;
      bitc_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      hit_q   <= 1'b0;
      flt_q   <= '0;
      bv_q    <= 1'b0;
      bd_q    <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      bitc_q  <= bitc_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      hit_q   <= hit_d;
      flt_q   <= flt_d;
      bv_q    <= bv_d;
      bd_q    <= bd_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  assign byte_valid_o = bv_q;
  assign byte_data_o  = bd_q;
  assign frame_ok_o   = ok_q;
  assign frame_err_o  = err_q;
  assign line_fault_o = flt_q;

  assert_vote_minority_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mm_i) <= NLINES / 2);
  assert_ok_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok_o && frame_err_o));
  assert_byte_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> $past(bit_en_i));
  assert_fault_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en_i) |-> $stable(line_fault_o));
  assert_ok_ends_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |-> ($past(state_q) == ST_CRC));
  assert_len_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (len_q != '0 && len_q <= LEN_W'(MAX_LEN)));
endmodule

// File: rtl/tlr_frame_rx.sv
module tlr_frame_rx
  import tlr_pkg::*;
#(
  parameter int NLINES  = 3,
  parameter int MAX_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [NLINES-1:0] line_in,
  input  logic [7:0]        node_addr,
  output logic              rx_byte_valid,
  output logic [7:0]        rx_byte,
  output logic              frame_ok,
  output logic              frame_err,
  output logic [NLINES-1:0] line_fault
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              voted;
  logic [NLINES-1:0] disagree;
  logic              crc_init, crc_step;
  logic [CRC_W-1:0]  crc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tlr_vote #(.NLINES(NLINES)) u_vote (
    .line_in  (line_in),
    .voted    (voted),
    .disagree (disagree)
  );

  tlr_crc_ser u_crc (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .init_i    (crc_init),
    .step_i    (crc_step),
    .bit_i     (voted),
    .crc_nxt_o (crc_nxt)
  );

  tlr_deframer #(.NLINES(NLINES), .MAX_LEN(MAX_LEN)) u_defr (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .bit_en_i     (bit_en),
    .vbit_i       (voted),
    .mm_i         (disagree),
    .my_addr_i    (node_addr),
    .crc_nxt_i    (crc_nxt),
    .crc_init_o   (crc_init),
    .crc_step_o   (crc_step),
    .byte_valid_o (rx_byte_valid),
    .byte_data_o  (rx_byte),
    .frame_ok_o   (frame_ok),
    .frame_err_o  (frame_err),
    .line_fault_o (line_fault)
  );
endmodule

// File: tb/tlr_frame_rx_tb.sv
module tlr_frame_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MY_ADDR = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [2:0] line_in = 3'b000;
  logic       rx_byte_valid, frame_ok, frame_err;
  logic [7:0] rx_byte;
  logic [2:0] line_fault;

  int nchk = 0, nfail = 0;
  int ncap = 0, nok = 0, nerr = 0;
  logic [7:0] cap [0:31];
  logic [7:0] expb [0:31];
  logic junk = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlr_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_in(line_in),
    .node_addr(MY_ADDR), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .frame_ok(frame_ok), .frame_err(frame_err), .line_fault(line_fault)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_byte_valid) begin
        if (ncap < 32) cap[ncap] = rx_byte;
        ncap++;
      end
      if (frame_ok)  nok++;
      if (frame_err) nerr++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fbk = r[15] ^ d[b];
      r = {r[14:0], 1'b0} ^ (fbk ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [7:0] pay(input int len, input int i);
    return (i == 2) ? 8'h7E : 8'(len * 29 + i * 13 + 5);
  endfunction

  task automatic send_bit(input logic [2:0] l);
    @(negedge clk);
    line_in = l;
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en  = 1'b0;
    if (junk) line_in = ~l;
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(3'b000);
  endtask

  // fmode: 0 none, 1 stuck low, 2 stuck high, 3 inverted (on line fline)
  task automatic send_frame(input logic [7:0] addr, input int len, input int fline,
                            input int fmode, input int cbit, input logic [2:0] cmask,
                            input logic bad_crc);
    logic [7:0]  fb [0:20];
    logic [15:0] c = 16'hFFFF;
    int n;
    int gi = 0;
    fb[0] = 8'h7E; fb[1] = addr; fb[2] = 8'(len);
    if (len < 1 || len > 16) begin
      n = 3;
    end else begin
      for (int i = 0; i < len; i++) begin
        fb[3 + i] = pay(len, i);
        expb[i]   = pay(len, i);
      end
      for (int i = 1; i < 3 + len; i++) c = crc_byte(c, fb[i]);
      fb[3 + len] = c[15:8];
      fb[4 + len] = c[7:0];
      if (bad_crc) fb[4 + len] = fb[4 + len] ^ 8'h01;
      n = 5 + len;
    end
    ncap = 0; nok = 0; nerr = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic       v = fb[i][b];
        logic [2:0] l = {3{v}};
        if (fmode == 1) l[fline] = 1'b0;
        if (fmode == 2) l[fline] = 1'b1;
        if (fmode == 3) l[fline] = ~v;
        if (gi == cbit) l = l ^ cmask;
        send_bit(l);
        gi++;
      end
    end
    idle_bits(10);
  endtask

  task automatic cmp_bytes(input string req, input int len);
    int lim = (ncap < len) ? ncap : len;
    for (int i = 0; i < lim; i++) chk(req, int'(cap[i]), int'(expb[i]));
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reset byte_valid", int'(rx_byte_valid), 0);
    chk("R10 reset frame_ok", int'(frame_ok), 0);
    chk("R10 reset frame_err", int'(frame_err), 0);
    chk("R10 reset line_fault", int'(line_fault), 0);

    // R3 R4 R7: clean frames, every legal length, payload holds 0x7E
    for (int len = 1; len <= 16; len++) begin
      send_frame(MY_ADDR, len, 0, 0, -1, 3'b000, 1'b0);
      chk("R4 frame_ok count", nok, 1);
      chk("R5 no error on clean frame", nerr, 0);
      chk("R7 byte count", ncap, len);
      cmp_bytes("R3 payload byte", len);
      chk("R9 clean fault mask", int'(line_fault), 0);
    end

    // R6 broadcast accepted
    send_frame(8'hFF, 4, 0, 0, -1, 3'b000, 1'b0);
    chk("R6 broadcast ok", nok, 1);
    chk("R6 broadcast bytes", ncap, 4);

    // R6 foreign address ignored, good and bad CRC
    send_frame(8'h33, 5, 0, 0, -1, 3'b000, 1'b0);
    chk("R6 foreign ok", nok, 0);
    chk("R6 foreign err", nerr, 0);
    chk("R6 foreign bytes", ncap, 0);
    send_frame(8'h33, 5, 0, 0, -1, 3'b000, 1'b1);
    chk("R6 foreign badcrc err", nerr, 0);
    chk("R6 foreign badcrc ok", nok, 0);

    // R5 bad CRC, bytes streamed anyway
    send_frame(MY_ADDR, 7, 0, 0, -1, 3'b000, 1'b1);
    chk("R5 bad crc err", nerr, 1);
    chk("R5 bad crc ok", nok, 0);
    chk("R7 bytes before verdict", ncap, 7);

    // R1 R9: every single-line fault mode on every line
    for (int ln = 0; ln < 3; ln++) begin
      for (int m = 1; m <= 3; m++) begin
        send_frame(MY_ADDR, 6, ln, m, -1, 3'b000, 1'b0);
        chk("R1 single fault ok", nok, 1);
        chk("R1 single fault err", nerr, 0);
        chk("R1 single fault bytes", ncap, 6);
        cmp_bytes("R1 single fault payload", 6);
        chk("R9 fault mask line", int'(line_fault), 1 << ln);
      end
    end

    // R1 R5 R9: two lines wrong at the same payload bit (vote is wrong)
    send_frame(MY_ADDR, 6, 0, 0, 8 * 4 + 3, 3'b011, 1'b0);
    chk("R5 double fault err", nerr, 1);
    chk("R1 double fault ok", nok, 0);
    chk("R9 mask names healthy line", int'(line_fault), 3'b100);

    // R9 cleared by next sync
    send_frame(MY_ADDR, 3, 0, 0, -1, 3'b000, 1'b0);
    chk("R9 mask cleared", int'(line_fault), 0);
    chk("R9 clean frame ok", nok, 1);

    // R8 illegal lengths
    send_frame(MY_ADDR, 0, 0, 0, -1, 3'b000, 1'b0);
    chk("R8 len0 err", nerr, 1);
    chk("R8 len0 bytes", ncap, 0);
    send_frame(MY_ADDR, 17, 0, 0, -1, 3'b000, 1'b0);
    chk("R8 len17 err", nerr, 1);
    chk("R8 len17 ok", nok, 0);
    send_frame(MY_ADDR, 2, 0, 0, -1, 3'b000, 1'b0);
    chk("R8 recovery ok", nok, 1);

    // R2: sync pattern on one line only starts nothing
    send_frame(MY_ADDR, 2, 2, 3, -1, 3'b000, 1'b0);
    chk("R2 setup mask", int'(line_fault), 3'b100);
    ncap = 0; nok = 0; nerr = 0;
    for (int r = 0; r < 6; r++) begin
      for (int b = 7; b >= 0; b--) send_bit({2'b00, r[0] ? MY_ADDR[b] : 1'(8'h7E >> b)});
    end
    idle_bits(40);
    chk("R2 lone sync bytes", ncap, 0);
    chk("R2 lone sync ok", nok, 0);
    chk("R2 lone sync err", nerr, 0);
    chk("R2 mask untouched", int'(line_fault), 3'b100);

    // R11: lines toggled between strobes
    junk = 1'b1;
    send_frame(MY_ADDR, 9, 0, 0, -1, 3'b000, 1'b0);
    junk = 1'b0;
    chk("R11 junk ok", nok, 1);
    chk("R11 junk bytes", ncap, 9);
    cmp_bytes("R11 junk payload", 9);
    chk("R11 junk mask", int'(line_fault), 0);

    finish_run();
  end
endmodule